// File: doc/BRIEF.md
# One-Time Programmable Security Register

This block models a 128-byte security register behind a serial slave port (SPI mode 0, most significant bit first). The lower 64 bytes form a user area that can be written exactly once. The upper 64 bytes hold a fixed per-device identifier, which is set by the `UID` parameter and can never be written. The serial lines are oversampled by the system clock. The system clock also times the program cycle.

A program transaction opens with the four-byte prefix 9Bh 00h 00h 00h, followed by data bytes. The data bytes go into a staging buffer. When chip select is released, the staging buffer is copied into the user area as a whole, and the busy flag is raised for `PROG_CYCLES` clocks. A read transaction opens with 77h and three dummy bytes, after which all 128 bytes stream out on SO in address order.

The control state machine has eight states:
- `ST_IDLE`: waits for chip select to fall, then goes to `ST_OPCODE`.
- `ST_OPCODE`: judges the first byte. 9Bh on a blank part goes to `ST_PROG_HDR`. 77h goes to `ST_RD_DUMMY`. Any other byte goes to `ST_IGNORE`.
- `ST_PROG_HDR`: needs three 00h bytes to reach `ST_PROG_DATA`. Any nonzero byte goes to `ST_IGNORE`.
- `ST_PROG_DATA`: stores data bytes in the staging buffer.
- `ST_RD_DUMMY`: consumes three bytes, then goes to `ST_RD_DATA`.
- `ST_RD_DATA`: drives SO.
- `ST_IGNORE`: waits out the rest of the frame.
- `ST_BUSY`: counts the program cycle. On expiry it returns to `ST_IDLE`, or to `ST_IGNORE` if chip select is already low.

A rising chip select in any frame state returns the machine to `ST_IDLE`. The one exception is `ST_PROG_DATA` after at least one complete data byte: that case goes to `ST_BUSY` and commits.

Top module: `otp_secreg`

## Requirements
- R1: After reset, `busy`, `programmed` and `so_oe` are all 0, and every user byte reads FFh.
- R2: Bits are sampled on rising SCK, most significant bit first. A program frame must start with exactly 9Bh, 00h, 00h, 00h. Data bytes that follow fill user locations 0, 1, 2 and so on.
- R3: A program frame whose prefix differs in any byte is ignored. No busy period follows, `programmed` stays 0 and the contents are unchanged.
- R4: Data beyond 64 bytes wraps, so data byte 64 (the 65th) lands at location 0 and byte 65 at location 1.
- R5: User locations that a short program burst does not reach read back as FFh.
- R6: Releasing CS_n after at least one complete data byte raises `busy` for exactly `PROG_CYCLES` system clocks, and `programmed` becomes 1 and stays 1.
- R7: Once `programmed` is 1, a further program frame starts no busy period and leaves every byte unchanged.
- R8: A read frame is 77h plus three dummy bytes. Register bytes 0 to 127 then appear on SO in order, MSB first, and SO changes after falling SCK. `so_oe` is 1 during this data phase.
- R9: `so_oe` is 0 whenever CS_n is high. SO is released within one clock of the synchronised rising edge.
- R10: Byte 64+k reads `UID[8k+7:8k]` and no program frame can change it.
- R11: Frames that start while `busy` is 1 are ignored. A read frame issued during busy never asserts `so_oe`.
- R12: A program frame that ends before one full data byte starts no busy period and sets no `programmed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for oversampling and the busy timer |
| rst_n | input | 1 | Active-low reset; models a blank part at power-up |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO; 0 means high impedance |
| busy | output | 1 | Program cycle in progress |
| programmed | output | 1 | User area has been committed |

## Verification
The bench builds the block with `PROG_CYCLES` = 300 and an identifier computed by the bench itself. With that cycle count, a read frame can be launched inside the busy window and the window's exact length can be counted. The serial clock half period is six system clocks, so synchronisation latency never masks a bit. Two reset-separated lifetimes bring both the short-burst fill and the 66-byte wrap within reach, even though the user area programs only once.

// File: rtl/otp_sec_pkg.sv
package otp_sec_pkg;

    localparam logic [7:0] CMD_PROGRAM = 8'h9B;
    localparam logic [7:0] CMD_READ    = 8'h77;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_PROG_HDR,
        ST_PROG_DATA,
        ST_RD_DUMMY,
        ST_RD_DATA,
        ST_IGNORE,
        ST_BUSY
    } sec_state_t;

endpackage

// File: rtl/otp_spi_rx.sv
module otp_spi_rx #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       si,
    output logic       cs_active,
    output logic       cs_start,
    output logic       cs_end,
    output logic       sck_fall,
    output logic       bit_zero,
    output logic       byte_valid,
    output logic [7:0] rx_byte
);

    logic [STAGES:0]   sck_q;
    logic [STAGES:0]   cs_q;
    logic [STAGES-1:0] si_q;
    logic [2:0]        bit_cnt;
    logic [6:0]        shreg;
    logic              sck_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= '0;
            cs_q  <= '1;
            si_q  <= '0;
        end else begin
            sck_q <= {sck_q[STAGES-1:0], sck};
            cs_q  <= {cs_q[STAGES-1:0], cs_n};
            si_q  <= {si_q[STAGES-2:0], si};
        end
    end

    assign sck_rise  = sck_q[STAGES-1] & ~sck_q[STAGES];
    assign sck_fall  = ~sck_q[STAGES-1] & sck_q[STAGES];
    assign cs_active = ~cs_q[STAGES-1];
    assign cs_start  = ~cs_q[STAGES-1] & cs_q[STAGES];
    assign cs_end    = cs_q[STAGES-1] & ~cs_q[STAGES];
    assign bit_zero  = (bit_cnt == 3'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            byte_valid <= 1'b0;
            rx_byte    <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (!cs_active) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg   <= {shreg[5:0], si_q[STAGES-1]};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_valid <= 1'b1;
                    rx_byte    <= {shreg, si_q[STAGES-1]};
                end
            end
        end
    end

endmodule

// File: rtl/otp_sec_ctrl.sv
module otp_sec_ctrl
    import otp_sec_pkg::*;
#(
    parameter int USER_BYTES  = 64,
    parameter int PROG_CYCLES = 20000,
    localparam int UA_W  = $clog2(USER_BYTES),
    localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_active,
    input  logic            cs_start,
    input  logic            cs_end,
    input  logic            byte_valid,
    input  logic [7:0]      rx_byte,
    output logic            stage_clear,
    output logic            stage_we,
    output logic [UA_W-1:0] wptr,
    output logic            commit,
    output logic            rd_start,
    output logic            rd_en,
    output logic            busy,
    output logic            programmed
);

    sec_state_t       state, state_nx;
    logic [1:0]       hdr_cnt;
    logic             got_data;
    logic [CNT_W-1:0] busy_cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (cs_start) state_nx = ST_OPCODE;
            ST_OPCODE: begin
                if (cs_end) state_nx = ST_IDLE;
                else if (byte_valid) begin
                    if (rx_byte == CMD_PROGRAM && !programmed) state_nx = ST_PROG_HDR;
                    else if (rx_byte == CMD_READ)              state_nx = ST_RD_DUMMY;
                    else                                       state_nx = ST_IGNORE;
                end
            end
            ST_PROG_HDR: begin
                if (cs_end) state_nx = ST_IDLE;
                else if (byte_valid) begin
                    if (rx_byte != 8'h00)     state_nx = ST_IGNORE;
                    else if (hdr_cnt == 2'd2) state_nx = ST_PROG_DATA;
                end
            end
            ST_PROG_DATA: if (cs_end) state_nx = got_data ? ST_BUSY : ST_IDLE;
            ST_RD_DUMMY: begin
                if (cs_end) state_nx = ST_IDLE;
                else if (byte_valid && hdr_cnt == 2'd2) state_nx = ST_RD_DATA;
            end
            ST_RD_DATA: if (cs_end) state_nx = ST_IDLE;
            ST_IGNORE:  if (cs_end) state_nx = ST_IDLE;
            ST_BUSY: begin
                if (busy_cnt == CNT_W'(PROG_CYCLES - 1))
                    state_nx = cs_active ? ST_IGNORE : ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        stage_clear = (state == ST_PROG_HDR) && byte_valid && !cs_end &&
                      (rx_byte == 8'h00) && (hdr_cnt == 2'd2);
        stage_we    = (state == ST_PROG_DATA) && byte_valid && !cs_end;
        commit      = (state == ST_PROG_DATA) && cs_end && got_data;
        rd_start    = (state == ST_RD_DUMMY) && byte_valid && !cs_end && (hdr_cnt == 2'd2);
        rd_en       = (state == ST_RD_DATA);
        busy        = (state == ST_BUSY);
    end

    // counters and sticky flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_cnt    <= '0;
            wptr       <= '0;
            got_data   <= 1'b0;
            busy_cnt   <= '0;
            programmed <= 1'b0;
        end else begin
            if (state == ST_OPCODE)
                hdr_cnt <= '0;
            else if (byte_valid && (state == ST_PROG_HDR || state == ST_RD_DUMMY))
                hdr_cnt <= hdr_cnt + 2'd1;

            if (stage_clear) begin
                wptr     <= '0;
                got_data <= 1'b0;
            end else if (stage_we) begin
                wptr     <= wptr + UA_W'(1);
                got_data <= 1'b1;
            end

            if (state == ST_BUSY) busy_cnt <= busy_cnt + CNT_W'(1);
            else                  busy_cnt <= '0;

            if (commit) programmed <= 1'b1;
        end
    end

    assert_commit_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !programmed);
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        programmed |=> programmed);
    assert_busy_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!stage_we && !rd_start && !stage_clear));
    assert_busy_follows_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);

endmodule

// File: rtl/otp_sec_array.sv
module otp_sec_array #(
    parameter int                      USER_BYTES = 64,
    parameter logic [USER_BYTES*8-1:0] UID        = '0,
    localparam int UA_W = $clog2(USER_BYTES),
    localparam int RA_W = UA_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stage_clear,
    input  logic            stage_we,
    input  logic [UA_W-1:0] wptr,
    input  logic [7:0]      wdata,
    input  logic            commit,
    input  logic            locked,
    input  logic            rd_start,
    input  logic            rd_en,
    input  logic            sck_fall,
    input  logic            bit_zero,
    output logic            so
);

    logic [USER_BYTES-1:0][7:0] user_mem;
    logic [USER_BYTES-1:0][7:0] stage;
    logic [RA_W-1:0]            rd_addr;
    logic [7:0]                 tx_sr;
    logic [7:0]                 rd_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage    <= '1;
            user_mem <= '1;
        end else begin
            if (stage_clear)   stage       <= '1;
            else if (stage_we) stage[wptr] <= wdata;
            if (commit)        user_mem    <= stage;
        end
    end

    always_comb begin
        if (rd_addr[RA_W-1]) rd_byte = UID[{rd_addr[UA_W-1:0], 3'b000} +: 8];
        else                 rd_byte = user_mem[rd_addr[UA_W-1:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_addr <= '0;
            tx_sr   <= '1;
        end else if (rd_start) begin
            rd_addr <= '0;
        end else if (rd_en && sck_fall) begin
            if (bit_zero) begin
                tx_sr   <= rd_byte;
                rd_addr <= rd_addr + RA_W'(1);
            end else begin
                tx_sr <= {tx_sr[6:0], 1'b1};
            end
        end
    end

    assign so = tx_sr[7];

    assert_user_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(user_mem));
    assert_no_write_while_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !commit);

endmodule

// File: rtl/otp_secreg.sv
module otp_secreg #(
    parameter int                      USER_BYTES  = 64,
    parameter int                      PROG_CYCLES = 20000,
    parameter int                      SYNC_STAGES = 2,
    parameter logic [USER_BYTES*8-1:0] UID         = {(USER_BYTES/4){32'h5EC0_1D42}}
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic so,
    output logic so_oe,
    output logic busy,
    output logic programmed
);

    localparam int UA_W = $clog2(USER_BYTES);

    logic            cs_active, cs_start, cs_end, sck_fall, bit_zero, byte_valid;
    logic [7:0]      rx_byte;
    logic            stage_clear, stage_we, commit, rd_start, rd_en;
    logic [UA_W-1:0] wptr;

    otp_spi_rx #(.STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .cs_active(cs_active), .cs_start(cs_start), .cs_end(cs_end),
        .sck_fall(sck_fall), .bit_zero(bit_zero),
        .byte_valid(byte_valid), .rx_byte(rx_byte)
    );

    otp_sec_ctrl #(.USER_BYTES(USER_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .cs_start(cs_start),
        .cs_end(cs_end), .byte_valid(byte_valid), .rx_byte(rx_byte),
        .stage_clear(stage_clear), .stage_we(stage_we), .wptr(wptr),
        .commit(commit), .rd_start(rd_start), .rd_en(rd_en),
        .busy(busy), .programmed(programmed)
    );

    otp_sec_array #(.USER_BYTES(USER_BYTES), .UID(UID)) u_array (
        .clk(clk), .rst_n(rst_n), .stage_clear(stage_clear), .stage_we(stage_we),
        .wptr(wptr), .wdata(rx_byte), .commit(commit), .locked(programmed),
        .rd_start(rd_start), .rd_en(rd_en), .sck_fall(sck_fall),
        .bit_zero(bit_zero), .so(so)
    );

    assign so_oe = rd_en;

    assert_so_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> !so_oe);

endmodule

// File: tb/otp_secreg_bench.sv
module otp_secreg_bench;

    localparam int UB   = 64;
    localparam int PC   = 300;
    localparam int HALF = 6;

    function automatic logic [UB*8-1:0] bench_uid();
        logic [UB*8-1:0] v;
        for (int k = 0; k < UB; k++) v[k*8 +: 8] = 8'((k * 37 + 11) ^ 8'hC6);
        return v;
    endfunction
    localparam logic [UB*8-1:0] BUID = bench_uid();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic so, so_oe, busy, programmed;

    always #10 clk = ~clk;

    otp_secreg #(.USER_BYTES(UB), .PROG_CYCLES(PC), .UID(BUID)) u_otp_secreg (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .so(so), .so_oe(so_oe), .busy(busy), .programmed(programmed)
    );

    int n_cmp = 0, n_bad = 0;
    logic [7:0] exp_mem [2*UB];
    bit  m_prog;
    bit  oe_seen;
    int  cs_hi_cnt = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reference model
    task automatic model_reset();
        for (int i = 0; i < UB; i++) exp_mem[i] = 8'hFF;
        for (int i = 0; i < UB; i++) exp_mem[UB+i] = BUID[i*8 +: 8];
        m_prog = 0;
    endtask

    task automatic model_program(input logic [7:0] d[$]);
        logic [7:0] st [UB];
        if (m_prog || d.size() == 0) return;
        for (int i = 0; i < UB; i++) st[i] = 8'hFF;
        foreach (d[i]) st[i % UB] = d[i];
        for (int i = 0; i < UB; i++) exp_mem[i] = st[i];
        m_prog = 1;
    endtask

    // per-clock comparison: SO released while chip select idles (R9)
    always @(negedge clk) begin
        if (cs_n) cs_hi_cnt++; else cs_hi_cnt = 0;
        if (rst_n && cs_hi_cnt >= 4) chk("R9 so_oe with cs_n high", 32'(so_oe), 32'd0);
    end

    // serial port driver
    task automatic spi_start();
        cs_n = 1'b0;
        oe_seen = 0;
        tick(HALF);
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            si = tx[b];
            tick(HALF);
            rx[b] = so;
            if (so_oe) oe_seen = 1;
            sck = 1'b1;
            tick(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic spi_stop();
        tick(HALF);
        cs_n = 1'b1;
        tick(2 * HALF);
    endtask

    task automatic send_frame(input logic [7:0] hdr[4], input logic [7:0] d[$]);
        logic [7:0] rx;
        spi_start();
        for (int i = 0; i < 4; i++) spi_byte(hdr[i], rx);
        foreach (d[i]) spi_byte(d[i], rx);
    endtask

    task automatic read_check(input string ureq);
        logic [7:0] rx;
        logic [7:0] h[4] = '{8'h77, 8'h00, 8'h00, 8'h00};
        spi_start();
        for (int i = 0; i < 4; i++) spi_byte(h[i], rx);
        for (int i = 0; i < 2 * UB; i++) begin
            spi_byte(8'h00, rx);
            if (i < UB) chk($sformatf("%s R8 user byte %0d", ureq, i), 32'(rx), 32'(exp_mem[i]));
            else        chk($sformatf("R10 id byte %0d", i), 32'(rx), 32'(exp_mem[i]));
        end
        chk("R8 so_oe during data", 32'(so_oe), 32'd1);
        spi_stop();
    endtask

    task automatic measure_busy(output int len);
        int t = 0;
        while (!busy && t < 60) begin tick(1); t++; end
        len = 0;
        while (busy && len < PC + 50) begin len++; tick(1); end
    endtask

    task automatic read_during_busy();
        logic [7:0] rx;
        spi_start();
        spi_byte(8'h77, rx);
        for (int i = 0; i < 5; i++) spi_byte(8'h00, rx);
        chk("R11 so_oe stays low for read issued while busy", 32'(oe_seen), 32'd0);
        spi_stop();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        model_reset();
    endtask

    initial begin
        logic [7:0] d[$];
        logic [7:0] hp[4] = '{8'h9B, 8'h00, 8'h00, 8'h00};
        logic [7:0] hb[4] = '{8'h9B, 8'h00, 8'h01, 8'h00};
        int len;

        do_reset();
        chk("R1 busy after reset", 32'(busy), 32'd0);
        chk("R1 programmed after reset", 32'(programmed), 32'd0);
        chk("R1 so_oe after reset", 32'(so_oe), 32'd0);
        read_check("R1");

        // R3: corrupted prefix
        d = '{8'h12, 8'h34, 8'h56};
        send_frame(hb, d);
        spi_stop();
        tick(20);
        chk("R3 no busy after bad prefix", 32'(busy), 32'd0);
        chk("R3 programmed after bad prefix", 32'(programmed), 32'd0);

        // R12: prefix with no data
        d = {};
        send_frame(hp, d);
        spi_stop();
        tick(20);
        chk("R12 no busy without data", 32'(busy), 32'd0);
        chk("R12 programmed without data", 32'(programmed), 32'd0);
        read_check("R3");

        // R2/R5/R6/R11: short burst
        d = '{8'hA1, 8'h02, 8'hC3, 8'h44, 8'h5E};
        send_frame(hp, d);
        model_program(d);
        fork
            measure_busy(len);
            begin spi_stop(); read_during_busy(); end
        join
        chk("R6 busy length", 32'(len), 32'(PC));
        chk("R6 programmed set", 32'(programmed), 32'd1);
        read_check("R2 R5");

        // R7: second program attempt
        d = {};
        for (int i = 0; i < 10; i++) d.push_back(8'h11);
        send_frame(hp, d);
        spi_stop();
        tick(20);
        chk("R7 no busy on reprogram", 32'(busy), 32'd0);
        chk("R7 programmed stays", 32'(programmed), 32'd1);
        read_check("R7");

        // R4: fresh part, 66-byte burst wraps
        do_reset();
        d = {};
        for (int i = 0; i < 66; i++) d.push_back(8'((i * 5 + 3) ^ 8'h3C));
        send_frame(hp, d);
        model_program(d);
        fork
            measure_busy(len);
            spi_stop();
        join
        chk("R6 busy length second part", 32'(len), 32'(PC));
        read_check("R4");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule